// File: doc/BRIEF.md
# I2C Command Target

This block is a target on a two-wire I2C bus. It responds to one fixed 7-bit address and runs a small command protocol over that bus. The core runs on a system clock and samples the bus lines through synchronisers. It finds start and stop conditions and SCL edges itself. It pulls SDA low through an open-drain style enable and never drives SCL.

A write transaction carries one command byte. Command 0x01 is followed by six payload bytes, which are stored in a register file. Command 0x10 only raises a completion event. Command 0x20 loads a fixed six-byte response. A later read transaction returns that response one byte at a time, and each further byte is sent only if the controller acknowledged the previous one. The payload, a one-cycle completion pulse and the last command code received are visible at the ports.

Top module: `i2c_cmd_target`

## Requirements
- R1: After a start, the 7 address bits followed by the R/W bit are received MSB first, with SDA sampled on each SCL rising edge. When the address equals `OWN_ADDR`, the block pulls SDA low for the ninth clock as the acknowledge.
- R2: When the address differs from `OWN_ADDR`, the block gives no acknowledge. It then ignores all bus traffic until the next start.
- R3: Code 0x01 is acknowledged and is followed by six data bytes, each of which is acknowledged. The first data byte is stored at index 5 and the last at index 0. Index i appears on `payload[8*i+7:8*i]`.
- R4: `cmd_done` is a pulse of exactly one cycle. It fires when code 0x10 is received, and when the sixth data byte after code 0x01 is received. It fires at no other time.
- R5: Code 0x20 is acknowledged and loads the response bytes DE, AD, BE, EF, CC, AA at indices 0 to 5. After a read address (R/W = 1) has been acknowledged, bytes are sent from index 0 upward, MSB first, with SDA changed only while SCL is low.
- R6: After each byte it sends, the block releases SDA and samples the controller's acknowledge. A high level (NACK) returns it to idle, so the next bits read as all ones.
- R7: Once the byte at index 5 has been sent and acknowledged, the block returns to idle and no longer drives SDA.
- R8: A command byte other than 0x01, 0x10 or 0x20 is not acknowledged and returns the block to idle.
- R9: `last_cmd` holds the most recent command byte received, known or unknown. It is 0 after reset.
- R10: A start condition seen in any state abandons the current transfer and begins a new address reception. Payload bytes already stored are kept.
- R11: A stop condition (SDA rising while SCL is high) returns the block to idle and releases SDA.
- R12: After reset, `sda_pull`, `cmd_done`, `last_cmd` and `payload` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| cmd_done | output | 1 | One-cycle command completion pulse |
| last_cmd | output | 8 | Most recent command byte |
| payload | output | 48 | Six received bytes, index i at bits 8i+7:8i |

## Verification
The assertions check, on every cycle, that SDA changes only while SCL is low and that `cmd_done` lasts a single cycle while SCL is high. They also check that `last_cmd` and `payload` change only while SCL is high, which is when bits are sampled. Behaviour that depends on bus sequences can only be shown by the bench scenarios. That covers which of the 128 addresses is acknowledged, the descending storage order, the response byte order, and gating on the controller's acknowledge. It also covers the abort on a repeated start and the return to idle after a stop.

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  output logic        cmd_done,
  output logic [7:0]  last_cmd,
  output logic [47:0] payload
);
  localparam int NB = 6;
  localparam logic [8*NB-1:0] RESP = 48'hDEADBEEFCCAA;

  typedef enum logic [2:0] {IDLE, ADDR, CMD, DATA, ACK, SEND, GACK} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st, ret;
  logic [3:0] cnt;
  logic [6:0] sh;
  logic [2:0] idx;
  logic [7:0] rx [NB];
  logic [7:0] tx [NB];

  wire scl_r = scl_q[1], scl_p = scl_q[2];
  wire sda_r = sda_q[1], sda_p = sda_q[2];
  wire rise  = scl_r & ~scl_p;
  wire fall  = ~scl_r & scl_p;
  wire start = scl_r & scl_p & sda_p & ~sda_r;
  wire stop  = scl_r & scl_p & ~sda_p & sda_r;
  wire [7:0] byte_in = {sh, sda_r};

  always_comb
    for (int i = 0; i < NB; i++) payload[8*i +: 8] = rx[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      ret      <= IDLE;
      cnt      <= '0;
      sh       <= '0;
      idx      <= '0;
      sda_pull <= 1'b0;
      cmd_done <= 1'b0;
      last_cmd <= '0;
      for (int i = 0; i < NB; i++) begin
        rx[i] <= '0;
        tx[i] <= '0;
      end
    end else begin
      cmd_done <= 1'b0;
      if (start) begin
        st       <= ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        st       <= IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ADDR, CMD, DATA: if (rise) begin
            sh  <= byte_in[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0;
              st  <= ACK;
              if (st == ADDR) begin
                idx <= '0;
                ret <= sda_r ? SEND : CMD;
                if (sh != OWN_ADDR) st <= IDLE;
              end else if (st == CMD) begin
                last_cmd <= byte_in;
                ret      <= IDLE;
                case (byte_in)
                  8'h01: begin ret <= DATA; idx <= 3'(NB - 1); end
                  8'h10: cmd_done <= 1'b1;
                  8'h20: for (int i = 0; i < NB; i++) tx[i] <= RESP[8*(NB-1-i) +: 8];
                  default: st <= IDLE;
                endcase
              end else begin
                rx[idx] <= byte_in;
                if (idx == 3'd0) begin
                  cmd_done <= 1'b1;
                  ret      <= IDLE;
                end else begin
                  idx <= idx - 3'd1;
                  ret <= DATA;
                end
              end
            end
          end
          ACK: if (fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              sda_pull <= (ret == SEND) ? ~tx[idx][7] : 1'b0;
              st       <= ret;
              cnt      <= '0;
            end
          end
          SEND: if (rise) cnt <= cnt + 4'd1;
                else if (fall) begin
                  if (cnt == 4'd8) begin
                    sda_pull <= 1'b0;
                    st       <= GACK;
                  end else sda_pull <= ~tx[idx][3'd7 - cnt[2:0]];
                end
          GACK: if (rise) begin
            if (sda_r || idx == 3'(NB - 1)) st <= IDLE;
            else begin
              idx <= idx + 3'd1;
              cnt <= '0;
              st  <= SEND;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_cmd_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_pull,
  input logic        cmd_done,
  input logic [7:0]  last_cmd,
  input logic [47:0] payload
);
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_i);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  a_r4_done_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> scl_i);
  a_r9_cmd_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cmd != $past(last_cmd)) |-> scl_i);
  a_r3_payload_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (payload != $past(payload)) |-> scl_i);
endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull),
  .cmd_done(cmd_done), .last_cmd(last_cmd), .payload(payload)
);

// File: tb/sim_i2c_cmd_target.sv
`timescale 1ns/1ps
module sim_i2c_cmd_target;
  localparam logic [6:0] ADR = 7'h2A;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0, ctl_scl = 1'b1, ctl_sda = 1'b1;
  logic sda_pull, cmd_done;
  logic [7:0] last_cmd;
  logic [47:0] payload;
  wire sda_bus = ctl_sda & ~sda_pull;
  int total = 0, bad = 0, ndone = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (cmd_done) ndone <= ndone + 1;

  i2c_cmd_target #(.OWN_ADDR(ADR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(ctl_scl), .sda_i(sda_bus),
    .sda_pull(sda_pull), .cmd_done(cmd_done), .last_cmd(last_cmd), .payload(payload));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    ctl_sda = 1'b1; tick(H); ctl_scl = 1'b1; tick(H);
    ctl_sda = 1'b0; tick(H); ctl_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    ctl_sda = 1'b0; tick(H); ctl_scl = 1'b1; tick(H); ctl_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    ctl_sda = b; tick(H); ctl_scl = 1'b1; tick(H); ctl_scl = 1'b0; tick(H);
  endtask

  task automatic get_bit(output logic b);
    ctl_sda = 1'b1; tick(H); ctl_scl = 1'b1; tick(H/2);
    b = sda_bus; tick(H/2); ctl_scl = 1'b0; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(ack);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int n0;
    logic [47:0] pl;
    logic [47:0] resp = 48'hDEADBEEFCCAA;
    tick(4);
    check(sda_pull == 0 && cmd_done == 0, "R12 outputs idle", {sda_pull, cmd_done}, 0);
    check(last_cmd == 0 && payload == 0, "R12 regs zero", {last_cmd, payload[31:0]}, 0);
    rst_n = 1'b1; tick(4);

    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      if (a == ADR) check(ack == 0, "R1 own address acked", ack, 0);
      else          check(ack == 1, "R2 foreign address not acked", ack, 1);
      if (a != ADR) begin
        put_byte(8'h10, ack);
        check(ack == 1, "R2 traffic ignored", ack, 1);
      end
      bus_stop();
    end
    check(ndone == 0, "R2 no event from foreign traffic", ndone, 0);

    bus_start(); put_byte({ADR, 1'b0}, ack); put_byte(8'h01, ack);
    check(ack == 0, "R3 code 01 acked", ack, 0);
    n0 = ndone;
    for (int i = 0; i < 6; i++) begin
      put_byte(8'h11 * 8'(i + 1), ack);
      check(ack == 0, "R3 data byte acked", ack, 0);
      if (i == 4) check(ndone == n0, "R4 no event before sixth byte", ndone, n0);
    end
    tick(2);
    check(ndone == n0 + 1, "R4 event after sixth byte", ndone, n0 + 1);
    check(payload == 48'h112233445566, "R3 descending store", payload, 48'h112233445566);
    check(last_cmd == 8'h01, "R9 last command 01", last_cmd, 8'h01);
    bus_stop();

    bus_start(); put_byte({ADR, 1'b0}, ack); n0 = ndone; put_byte(8'h10, ack);
    check(ack == 0, "R4 code 10 acked", ack, 0);
    check(ndone == n0 + 1, "R4 event on code 10", ndone, n0 + 1);
    check(last_cmd == 8'h10, "R9 last command 10", last_cmd, 8'h10);
    bus_stop();

    bus_start(); put_byte({ADR, 1'b0}, ack); n0 = ndone; put_byte(8'h55, ack);
    check(ack == 1, "R8 unknown code not acked", ack, 1);
    check(last_cmd == 8'h55, "R9 last command unknown", last_cmd, 8'h55);
    put_byte(8'h10, ack);
    check(ack == 1 && ndone == n0, "R8 idle after unknown", {ack, 8'(ndone)}, {1'b1, 8'(n0)});
    bus_stop();

    bus_start(); put_byte({ADR, 1'b0}, ack); put_byte(8'h20, ack);
    check(ack == 0, "R5 code 20 acked", ack, 0);
    bus_stop();
    bus_start(); put_byte({ADR, 1'b1}, ack);
    check(ack == 0, "R1 read address acked", ack, 0);
    for (int i = 0; i < 6; i++) begin
      get_byte(1'b0, d);
      check(d == resp[8*(5-i) +: 8], "R5 response byte", d, resp[8*(5-i) +: 8]);
    end
    get_byte(1'b1, d);
    check(d == 8'hFF, "R7 released after last byte", d, 8'hFF);
    bus_stop();

    bus_start(); put_byte({ADR, 1'b1}, ack);
    get_byte(1'b0, d);
    check(d == 8'hDE, "R5 first byte again", d, 8'hDE);
    get_byte(1'b1, d);
    check(d == 8'hAD, "R5 second byte", d, 8'hAD);
    get_byte(1'b1, d);
    check(d == 8'hFF, "R6 idle after NACK", d, 8'hFF);
    bus_stop();

    bus_start(); put_byte({ADR, 1'b0}, ack); put_byte(8'h01, ack);
    put_byte(8'h77, ack); put_byte(8'h88, ack);
    n0 = ndone;
    bus_start(); put_byte({ADR, 1'b0}, ack);
    check(ack == 0, "R10 restart address acked", ack, 0);
    put_byte(8'h10, ack);
    check(ack == 0 && ndone == n0 + 1, "R10 restart command runs", {ack, 8'(ndone)}, {1'b0, 8'(n0 + 1)});
    pl = 48'h778833445566;
    check(payload == pl, "R10 partial payload kept", payload, pl);
    bus_stop();

    bus_start(); put_byte({ADR, 1'b0}, ack);
    bus_stop();
    check(sda_pull == 0, "R11 SDA released at stop", sda_pull, 0);
    n0 = ndone;
    ctl_scl = 1'b0; tick(H);
    put_byte(8'h10, ack);
    check(ack == 1 && ndone == n0, "R11 idle after stop", {ack, 8'(ndone)}, {1'b1, 8'(n0)});
    check(last_cmd == 8'h10, "R11 command kept", last_cmd, 8'h10);
    ctl_scl = 1'b1; tick(H);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule